// File: doc/BRIEF.md
# Monitor Channel Handshake Controller

This block moves message bytes across the monitor slot of a time-multiplexed serial frame, in both directions. Once per frame, on a one-cycle frame strobe, it samples the slot contents that arrived from the remote controller: a data byte, a receive-acknowledge bit and a transmit-valid bit. In the same cycle it updates the data byte and the two handshake bits that it sends back. Both handshake bits are active low and rest high. The slot is already deserialized, so the block only works at byte and bit level.

On the local side, bytes to send enter on a valid/ready port. The ready signal can only be high during a frame strobe. A byte is taken in the strobe cycle where valid and ready are both high; otherwise the source keeps valid and data steady. Received bytes leave on a second valid/ready port. A byte stays presented until the sink raises ready. While it is still unread, the block withholds its acknowledge on the line, which back-pressures the remote sender.

An optional time-out returns both directions to idle at two fixed frame positions of each 96-frame superframe. If a transfer was in progress at that moment, an abort pulse is raised. A channel-enable input lets the whole channel be ignored in operating modes where it does not exist.

Top module: `mon_hs_ctrl`

## Requirements
- R1: After reset, line_mr_out and line_mx_out are 1 (1 = idle, 0 = active), line_data_out is 8'hFF, and rcv_valid, rcv_eom and xfer_abort are 0.
- R2: snd_ready is high only in a frame-strobe cycle. When an idle transmitter takes a byte, line_data_out carries that byte and line_mx_out is 0 from that strobe on.
- R3: A sent byte stays on line_data_out with line_mx_out at 0 until a later strobe samples line_mr_in at 0. A 0 on line_mr_in in the first frame after a byte is loaded does not count as acknowledgment.
- R4: If snd_valid is high at the strobe that sees the acknowledgment, the next byte is taken in that same strobe and line_mx_out stays 0.
- R5: If no byte is offered at the acknowledgment, line_mx_out goes to 1 for exactly two frames. No new byte is taken before the strobe after those two frames.
- R6: A received byte is accepted when line_mx_in is 0 in two consecutive frames with the same data byte. Acceptance sets rcv_valid and rcv_data, and drives line_mr_out to 0 for exactly one frame. The byte that arrives during that acknowledgment frame is stored only as the reference for the next comparison.
- R7: While rcv_valid is high and rcv_ready is low, no further byte is accepted, line_mr_out stays 1, and rcv_data stays unchanged.
- R8: After at least one byte of a message has been accepted, two consecutive frames with line_mx_in at 1 produce a one-cycle rcv_eom pulse.
- R9: With tmo_en at 1, a strobe at frame_num 1 or 49 resets the transmitter and the receiver together. Both line handshake bits become 1, any byte in flight or partly compared is discarded, and snd_ready stays low in that strobe.
- R10: xfer_abort pulses for one cycle after a time-out strobe that interrupts a busy transmitter (waiting for acknowledgment) or a busy receiver. It stays 0 when both are idle.
- R11: With tmo_en at 0, frames 1 and 49 behave like any other frame, and xfer_abort never rises.
- R12: While chan_en is 0, all line and local inputs are ignored. line_mr_out and line_mx_out are 1, snd_ready is 0, and no byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel present in the current mode |
| tmo_en | input | 1 | Enable for the superframe time-out |
| frame_stb | input | 1 | One-cycle pulse per frame |
| frame_num | input | 7 | Frame position in the superframe, 1 to 96 |
| line_data_in | input | 8 | Monitor byte received from the slot |
| line_mr_in | input | 1 | Remote acknowledge, active low |
| line_mx_in | input | 1 | Remote data-valid, active low |
| line_data_out | output | 8 | Monitor byte sent on the slot |
| line_mr_out | output | 1 | Local acknowledge, active low |
| line_mx_out | output | 1 | Local data-valid, active low |
| snd_valid | input | 1 | Byte to send is offered |
| snd_ready | output | 1 | Byte taken this cycle |
| snd_data | input | 8 | Byte to send |
| rcv_valid | output | 1 | Received byte presented |
| rcv_ready | input | 1 | Sink takes the received byte |
| rcv_data | output | 8 | Received byte |
| rcv_eom | output | 1 | End-of-message pulse from the remote side |
| xfer_abort | output | 1 | Time-out cut a transfer short |

## Verification
The bench drives a stale acknowledge in the frame right after a byte is loaded. A transmitter that accepted it would drop the byte before the remote side could have compared it. It offers the next byte at the acknowledgment frame and after it, which catches a design that inserts an idle frame or shortens the two-frame end-of-message gap. On receive it holds rcv_ready low while a matching byte repeats; a design without back-pressure would overwrite unread data or acknowledge it. It also places a half-received byte across a time-out frame; a design that kept the stale reference would accept that byte one frame early. The enabled, disabled and idle time-out cases separate a missing reset from a spurious abort.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_END  = 2'd2
  } tx_st_t;
endpackage

// File: rtl/mon_tmo.sv
module mon_tmo #(
  parameter int SF_LEN = 96,
  parameter int FNW    = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stb,
  input  logic           en,
  input  logic           tmo_en,
  input  logic [FNW-1:0] frame_num,
  input  logic           tx_busy,
  input  logic           rx_busy,
  output logic           clr,
  output logic           abort
);
  localparam int NPOS = 2;
  localparam int POS_STEP = SF_LEN / NPOS;

  logic [NPOS-1:0] pos_hit;
  logic            hit;

  for (genvar i = 0; i < NPOS; i++) begin : g_pos
    assign pos_hit[i] = (frame_num == FNW'(1 + i * POS_STEP));
  end

  assign hit = stb && en && tmo_en && (|pos_hit);
  assign clr = stb && (!en || hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort <= 1'b0;
    else        abort <= hit && (tx_busy || rx_busy);
  end
endmodule

// File: rtl/mon_tx.sv
module mon_tx
  import mon_hs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          clr,
  input  logic          mr_in,
  input  logic          snd_valid,
  input  logic [DW-1:0] snd_data,
  output logic          snd_ready,
  output logic [DW-1:0] data_out,
  output logic          mx_out,
  output logic          busy
);
  tx_st_t st;
  logic   fresh;
  logic   acked;

  assign acked     = (st == TX_WAIT) && !fresh && !mr_in;
  assign snd_ready = stb && !clr && ((st == TX_IDLE) || acked);
  assign busy      = (st == TX_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      data_out <= '1;
      mx_out   <= 1'b1;
      fresh    <= 1'b0;
    end else if (clr) begin
      st       <= TX_IDLE;
      data_out <= '1;
      mx_out   <= 1'b1;
      fresh    <= 1'b0;
    end else if (stb) begin
      case (st)
        TX_IDLE: begin
          if (snd_valid) begin
            data_out <= snd_data;
            mx_out   <= 1'b0;
            fresh    <= 1'b1;
            st       <= TX_WAIT;
          end
        end
        TX_WAIT: begin
          fresh <= 1'b0;
          if (acked) begin
            if (snd_valid) begin
              data_out <= snd_data;
              fresh    <= 1'b1;
            end else begin
              mx_out <= 1'b1;
              st     <= TX_END;
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mon_rx.sv
module mon_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic          clr,
  input  logic [DW-1:0] data_in,
  input  logic          mx_in,
  input  logic          rcv_ready,
  output logic          rcv_valid,
  output logic [DW-1:0] rcv_data,
  output logic          mr_out,
  output logic          eom,
  output logic          busy
);
  logic [DW-1:0] ref_d;
  logic          ref_ok;
  logic          in_msg;
  logic          idle1;
  logic          blocked;
  logic          match;

  assign blocked = rcv_valid && !rcv_ready;
  assign match   = ref_ok && mr_out && (data_in == ref_d) && !blocked;
  assign busy    = in_msg || ref_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d     <= '1;
      ref_ok    <= 1'b0;
      in_msg    <= 1'b0;
      idle1     <= 1'b0;
      mr_out    <= 1'b1;
      rcv_valid <= 1'b0;
      rcv_data  <= '0;
      eom       <= 1'b0;
    end else begin
      eom <= 1'b0;
      if (rcv_valid && rcv_ready) rcv_valid <= 1'b0;
      if (clr) begin
        ref_ok <= 1'b0;
        in_msg <= 1'b0;
        idle1  <= 1'b0;
        mr_out <= 1'b1;
      end else if (stb) begin
        mr_out <= 1'b1;
        if (!mx_in) begin
          idle1  <= 1'b0;
          ref_d  <= data_in;
          ref_ok <= 1'b1;
          if (match) begin
            rcv_valid <= 1'b1;
            rcv_data  <= data_in;
            mr_out    <= 1'b0;
            in_msg    <= 1'b1;
          end
        end else begin
          ref_ok <= 1'b0;
          if (in_msg) begin
            if (idle1) begin
              eom    <= 1'b1;
              in_msg <= 1'b0;
              idle1  <= 1'b0;
            end else begin
              idle1 <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mon_hs_ctrl.sv
module mon_hs_ctrl #(
  parameter int DW     = 8,
  parameter int SF_LEN = 96,
  parameter int FNW    = $clog2(SF_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          tmo_en,
  input  logic          frame_stb,
  input  logic [FNW-1:0] frame_num,
  input  logic [DW-1:0] line_data_in,
  input  logic          line_mr_in,
  input  logic          line_mx_in,
  output logic [DW-1:0] line_data_out,
  output logic          line_mr_out,
  output logic          line_mx_out,
  input  logic          snd_valid,
  output logic          snd_ready,
  input  logic [DW-1:0] snd_data,
  output logic          rcv_valid,
  input  logic          rcv_ready,
  output logic [DW-1:0] rcv_data,
  output logic          rcv_eom,
  output logic          xfer_abort
);
  logic clr;
  logic tx_busy;
  logic rx_busy;

  mon_tmo #(.SF_LEN(SF_LEN), .FNW(FNW)) u_tmo (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .en(chan_en),
    .tmo_en(tmo_en), .frame_num(frame_num), .tx_busy(tx_busy),
    .rx_busy(rx_busy), .clr(clr), .abort(xfer_abort)
  );

  mon_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .clr(clr),
    .mr_in(line_mr_in), .snd_valid(snd_valid), .snd_data(snd_data),
    .snd_ready(snd_ready), .data_out(line_data_out), .mx_out(line_mx_out),
    .busy(tx_busy)
  );

  mon_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .stb(frame_stb), .clr(clr),
    .data_in(line_data_in), .mx_in(line_mx_in), .rcv_ready(rcv_ready),
    .rcv_valid(rcv_valid), .rcv_data(rcv_data), .mr_out(line_mr_out),
    .eom(rcv_eom), .busy(rx_busy)
  );
endmodule

// File: rtl/mon_hs_ctrl_chk.sv
module mon_hs_ctrl_chk #(
  parameter int DW     = 8,
  parameter int SF_LEN = 96,
  parameter int FNW    = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           chan_en,
  input logic           tmo_en,
  input logic           frame_stb,
  input logic [FNW-1:0] frame_num,
  input logic [DW-1:0]  line_data_out,
  input logic           line_mr_out,
  input logic           line_mx_out,
  input logic           snd_ready,
  input logic           rcv_valid,
  input logic           rcv_ready,
  input logic [DW-1:0]  rcv_data,
  input logic           xfer_abort
);
  localparam int POS_B = SF_LEN / 2 + 1;

  logic at_pos;
  assign at_pos = (frame_num == FNW'(1)) || (frame_num == FNW'(POS_B));

  // R2
  ready_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_ready |-> (frame_stb && chan_en));

  // R2
  line_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> ($stable(line_mx_out) && $stable(line_mr_out) && $stable(line_data_out)));

  // R6
  ack_one_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !line_mr_out) |=> line_mr_out);

  // R7
  rcv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_valid && !rcv_ready) |=> (rcv_valid && $stable(rcv_data)));

  // R9
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && chan_en && tmo_en && at_pos) |=> (line_mx_out && line_mr_out));

  // R11
  no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_stb || !tmo_en) |=> !xfer_abort);

  // R12
  chan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !chan_en) |=> (line_mx_out && line_mr_out && !snd_ready));
endmodule

bind mon_hs_ctrl mon_hs_ctrl_chk #(.DW(DW), .SF_LEN(SF_LEN), .FNW(FNW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tmo_en(tmo_en),
  .frame_stb(frame_stb), .frame_num(frame_num), .line_data_out(line_data_out),
  .line_mr_out(line_mr_out), .line_mx_out(line_mx_out), .snd_ready(snd_ready),
  .rcv_valid(rcv_valid), .rcv_ready(rcv_ready), .rcv_data(rcv_data),
  .xfer_abort(xfer_abort)
);

// File: tb/mon_hs_ctrl_test.sv
module mon_hs_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chan_en = 1'b1;
  logic       tmo_en = 1'b0;
  logic       frame_stb = 1'b0;
  logic [6:0] frame_num = 7'd10;
  logic [7:0] line_data_in = 8'hFF;
  logic       line_mr_in = 1'b1;
  logic       line_mx_in = 1'b1;
  logic [7:0] line_data_out;
  logic       line_mr_out;
  logic       line_mx_out;
  logic       snd_valid = 1'b0;
  logic       snd_ready;
  logic [7:0] snd_data = 8'h00;
  logic       rcv_valid;
  logic       rcv_ready = 1'b0;
  logic [7:0] rcv_data;
  logic       rcv_eom;
  logic       xfer_abort;

  int total = 0;
  int bad = 0;
  logic took;

  always #10 clk = ~clk;

  mon_hs_ctrl uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tmo_en(tmo_en),
    .frame_stb(frame_stb), .frame_num(frame_num), .line_data_in(line_data_in),
    .line_mr_in(line_mr_in), .line_mx_in(line_mx_in), .line_data_out(line_data_out),
    .line_mr_out(line_mr_out), .line_mx_out(line_mx_out), .snd_valid(snd_valid),
    .snd_ready(snd_ready), .snd_data(snd_data), .rcv_valid(rcv_valid),
    .rcv_ready(rcv_ready), .rcv_data(rcv_data), .rcv_eom(rcv_eom),
    .xfer_abort(xfer_abort)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one frame: drive slot inputs, pulse strobe, note whether a send byte was taken
  task automatic frame(input int fn, input logic [7:0] d, input logic mr, input logic mx);
    @(negedge clk);
    frame_num = 7'(fn);
    line_data_in = d;
    line_mr_in = mr;
    line_mx_in = mx;
    frame_stb = 1'b1;
    #1 took = snd_valid && snd_ready;
    @(negedge clk);
    frame_stb = 1'b0;
    if (took) snd_valid = 1'b0;
  endtask

  task automatic take_rcv();
    @(negedge clk);
    rcv_ready = 1'b1;
    @(negedge clk);
    rcv_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mx idle", line_mx_out, 1);
    chk("R1 mr idle", line_mr_out, 1);
    chk("R1 data FF", line_data_out, 8'hFF);
    chk("R1 rcv_valid", rcv_valid, 0);
    chk("R1 abort", xfer_abort, 0);
    chk("R1 eom", rcv_eom, 0);
  endtask

  task automatic t_tx_single();
    snd_valid = 1'b1; snd_data = 8'hA5;
    frame(11, 8'hFF, 1, 1);
    chk("R2 taken", took, 1);
    chk("R2 data", line_data_out, 8'hA5);
    chk("R2 mx active", line_mx_out, 0);
    frame(12, 8'hFF, 0, 1);
    chk("R3 early mr ignored", line_mx_out, 0);
    frame(13, 8'hFF, 1, 1);
    chk("R3 held data", line_data_out, 8'hA5);
    chk("R3 held mx", line_mx_out, 0);
    frame(14, 8'hFF, 0, 1);
    chk("R5 mx idle after ack", line_mx_out, 1);
    snd_valid = 1'b1; snd_data = 8'h3C;
    frame(15, 8'hFF, 1, 1);
    chk("R5 not taken in gap", took, 0);
    chk("R5 mx still idle", line_mx_out, 1);
    frame(16, 8'hFF, 1, 1);
    chk("R5 taken after gap", took, 1);
    chk("R5 new data", line_data_out, 8'h3C);
    frame(17, 8'hFF, 1, 1);
    frame(18, 8'hFF, 0, 1);
    chk("R3 ack ends", line_mx_out, 1);
    frame(19, 8'hFF, 1, 1);
  endtask

  task automatic t_tx_burst();
    snd_valid = 1'b1; snd_data = 8'h11;
    frame(20, 8'hFF, 1, 1);
    chk("R2 first taken", took, 1);
    frame(21, 8'hFF, 1, 1);
    snd_valid = 1'b1; snd_data = 8'h22;
    frame(22, 8'hFF, 0, 1);
    chk("R4 next taken at ack", took, 1);
    chk("R4 next data", line_data_out, 8'h22);
    chk("R4 mx stays active", line_mx_out, 0);
    frame(23, 8'hFF, 0, 1);
    chk("R3 stale mr after reload", line_mx_out, 0);
    frame(24, 8'hFF, 0, 1);
    chk("R5 end", line_mx_out, 1);
    frame(25, 8'hFF, 1, 1);
  endtask

  task automatic t_rx();
    frame(30, 8'h5A, 1, 0);
    chk("R6 single frame no accept", rcv_valid, 0);
    chk("R6 no mr yet", line_mr_out, 1);
    frame(31, 8'h5A, 1, 0);
    chk("R6 accepted", rcv_valid, 1);
    chk("R6 data", rcv_data, 8'h5A);
    chk("R6 mr active", line_mr_out, 0);
    frame(32, 8'h6B, 1, 0);
    chk("R6 mr one frame", line_mr_out, 1);
    chk("R6 ack frame kept old", rcv_data, 8'h5A);
    frame(33, 8'h6B, 1, 0);
    chk("R7 no mr while full", line_mr_out, 1);
    chk("R7 data stable", rcv_data, 8'h5A);
    take_rcv();
    chk("R7 taken", rcv_valid, 0);
    frame(34, 8'h6B, 1, 0);
    chk("R7 accept after drain", rcv_data, 8'h6B);
    chk("R6 mr again", line_mr_out, 0);
    take_rcv();
    frame(35, 8'hFF, 1, 1);
    chk("R8 no eom after one idle", rcv_eom, 0);
    frame(36, 8'hFF, 1, 1);
    chk("R8 eom", rcv_eom, 1);
    frame(37, 8'h10, 1, 0);
    frame(38, 8'h20, 1, 0);
    chk("R6 mismatch no accept", rcv_valid, 0);
    frame(39, 8'h20, 1, 0);
    chk("R6 match accept", rcv_data, 8'h20);
    take_rcv();
    frame(40, 8'hFF, 1, 1);
    frame(41, 8'hFF, 1, 1);
  endtask

  task automatic t_tmo();
    tmo_en = 1'b1;
    snd_valid = 1'b1; snd_data = 8'h99;
    frame(47, 8'hFF, 1, 1);
    frame(48, 8'hFF, 1, 1);
    chk("R9 no reset at 48", line_mx_out, 0);
    snd_valid = 1'b1; snd_data = 8'h44;
    frame(49, 8'hFF, 0, 1);
    chk("R9 not taken at tmo", took, 0);
    chk("R9 mx idle", line_mx_out, 1);
    chk("R9 mr idle", line_mr_out, 1);
    chk("R10 abort tx", xfer_abort, 1);
    @(negedge clk);
    chk("R10 abort one cycle", xfer_abort, 0);
    frame(50, 8'hFF, 1, 1);
    chk("R9 fresh start", took, 1);
    frame(51, 8'hFF, 1, 1);
    frame(52, 8'hFF, 0, 1);
    frame(53, 8'hFF, 1, 1);
    frame(96, 8'h77, 1, 0);
    frame(1, 8'h77, 1, 0);
    chk("R10 abort rx", xfer_abort, 1);
    chk("R9 rx none at tmo", rcv_valid, 0);
    frame(2, 8'h77, 1, 0);
    chk("R9 partial discarded", rcv_valid, 0);
    frame(3, 8'h77, 1, 0);
    chk("R9 accept after restart", rcv_valid, 1);
    take_rcv();
    frame(4, 8'hFF, 1, 1);
    frame(5, 8'hFF, 1, 1);
    frame(49, 8'hFF, 1, 1);
    chk("R10 no abort when idle", xfer_abort, 0);
    tmo_en = 1'b0;
  endtask

  task automatic t_tmo_off();
    snd_valid = 1'b1; snd_data = 8'h5C;
    frame(47, 8'hFF, 1, 1);
    frame(48, 8'hFF, 1, 1);
    frame(49, 8'hFF, 1, 1);
    chk("R11 no reset at 49", line_mx_out, 0);
    chk("R11 no abort", xfer_abort, 0);
    frame(50, 8'hFF, 0, 1);
    chk("R11 normal ack", line_mx_out, 1);
    frame(51, 8'hFF, 1, 1);
  endtask

  task automatic t_chan_off();
    chan_en = 1'b0;
    snd_valid = 1'b1; snd_data = 8'hAA;
    frame(60, 8'h12, 1, 0);
    chk("R12 send ignored", took, 0);
    frame(61, 8'h12, 1, 0);
    chk("R12 rx ignored", rcv_valid, 0);
    chk("R12 mx idle", line_mx_out, 1);
    chk("R12 mr idle", line_mr_out, 1);
    chan_en = 1'b1;
    snd_valid = 1'b0;
    frame(62, 8'hFF, 1, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_single();
    t_tx_burst();
    t_rx();
    t_tmo();
    t_tmo_off();
    t_chan_off();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule